// File: doc/BRIEF.md
# Banked ROM Disk Window

This block maps one 64 KiB window of a read-only disk image into the processor memory map. The image lives in a 512 KiB ROM array outside the block. An 8-bit control register, written over the I/O side, holds a window-enable flag and a bank number. When the window is enabled and a ROM image is fitted, a memory read whose address falls in the window range is translated into a ROM address. The ROM data comes back as a one-cycle response that is flagged as a hit. An external bus decoder uses that hit flag to give the window priority over ordinary RAM in the same range.

Reads that the window does not claim still get a response, one strobe per accepted read. The response carries hit low and data of all ones, so the bus side always sees a fixed response time. The control register can be read back at any time.

A four-state machine sequences each accepted read:
- IDLE waits for a read strobe and latches the translated address, the claim decision and the access width. It then moves to ISSUE.
- ISSUE drives the ROM request, but only when the read is claimed. It then moves to WAIT.
- WAIT captures the ROM data. It then moves to RESP.
- RESP presents the response for one cycle. It then returns to IDLE.

Top module: `rom_bank_window`

## Requirements
- R1: After reset the control register reads 0x00, and the window claims no read.
- R2: A write to the control register is visible on `ctrl_rdata` from the next cycle, exactly as written.
- R3: With control bit 7 at 0, a read in the window range is not claimed. It responds with hit 0 and data 0xFFFF, and no ROM request is made.
- R4: With bit 7 at 1 and a ROM image present, a byte read at window address A issues ROM address (bank mod 8)·0x10000 + A[15:0]. Here the bank is control bits 6:0. The response has hit 1, the ROM byte at that address in bits 7:0, and 0xFF in bits 15:8.
- R5: Bank numbers wrap modulo the ROM size: bank b and bank b+8 reach the same ROM bytes.
- R6: With `rom_present` low, no read is claimed even when bit 7 is set. The response is hit 0 with data 0xFFFF, and `rom_req` stays low.
- R7: A read whose address bits 19:16 are not 0xA is not claimed, whatever the control register holds.
- R8: A 16-bit read (`mem_wide` = 1) returns the ROM byte at the translated address in bits 7:0 and the byte at the next ROM address in bits 15:8. The next address wraps modulo 512 KiB.
- R9: Each accepted read gives exactly one `rsp_valid` pulse, one cycle long, in the cycle after the third clock edge counted from the edge that samples `mem_rd`. `hit` is high only with `rsp_valid`.
- R10: A read strobe that arrives while a read is in flight is ignored and produces no response.
- R11: A control write made while a read is in flight does not change the address or the claim of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_we | input | 1 | Control register write strobe |
| io_wdata | input | 8 | Control value: bit 7 enable, bits 6:0 bank |
| ctrl_rdata | output | 8 | Control register readback |
| rom_present | input | 1 | High when a ROM image is fitted |
| mem_rd | input | 1 | Memory read strobe, one cycle |
| mem_addr | input | 20 | Memory read address |
| mem_wide | input | 1 | 1 for a 16-bit read, 0 for a byte read |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | 19 | ROM byte address |
| rom_rdata | input | 16 | ROM data one cycle after request: {byte at addr+1, byte at addr} |
| rsp_valid | output | 1 | Response strobe, one cycle per accepted read |
| hit | output | 1 | Window claimed this read |
| rsp_data | output | 16 | Read data |

## Verification
A read strobe sampled at one edge moves the machine through ISSUE and WAIT, so its response is due in the cycle after the third edge from that point. A control write shows on the readback one edge later. The driver pushes the expected response for each accepted read into a queue. A monitor samples on the falling clock edge and pops one entry on each `rsp_valid`, so an early, late, missing or extra response appears as a mismatch or as an unexpected pop. The driver spaces reads five cycles apart, which leaves room for exactly one response, except where a second strobe is sent on purpose while a read is in flight.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

    // FSM encoding for the read sequencer
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_RESP  = 2'd3
    } rbw_state_e;

    // Captured read request
    typedef struct packed {
        logic        claim;
        logic        wide;
        logic [18:0] raddr;
    } rbw_req_t;

endpackage

// File: rtl/rbw_ctrl_reg.sv
module rbw_ctrl_reg #(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_we,
    input  logic [CTRL_W-1:0] io_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              win_en,
    output logic [CTRL_W-2:0] bank
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (io_we) begin
            ctrl_q <= io_wdata;
        end
    end

    // Top bit enables, remaining bits select a bank
    assign win_en = ctrl_q[CTRL_W-1];
    assign bank   = ctrl_q[CTRL_W-2:0];
endmodule

// File: rtl/rbw_xlat.sv
module rbw_xlat #(
    parameter int             ADDR_W   = 20,
    parameter int             WIN_LOG2 = 16,
    parameter int             ROM_LOG2 = 19,
    parameter int             BANK_W   = 7,
    parameter logic [ADDR_W-WIN_LOG2-1:0] WIN_TAG = 'hA
) (
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic                win_en,
    input  logic [BANK_W-1:0]   bank,
    input  logic                rom_present,
    output logic                claim,
    output logic [ROM_LOG2-1:0] raddr
);
    localparam int TAG_W     = ADDR_W - WIN_LOG2;
    localparam int BANK_USED = ROM_LOG2 - WIN_LOG2;

    logic in_range;
    assign in_range = (mem_addr[ADDR_W-1:WIN_LOG2] == WIN_TAG[TAG_W-1:0]);
    assign claim    = in_range && win_en && rom_present;

    // Bank offset modulo ROM size: keep only the bank bits that fit the ROM
    generate
        if (BANK_USED <= 0) begin : g_single_bank
            assign raddr = mem_addr[ROM_LOG2-1:0];
        end else if (BANK_USED >= BANK_W) begin : g_wide_rom
            assign raddr = {{(BANK_USED-BANK_W){1'b0}}, bank, mem_addr[WIN_LOG2-1:0]};
        end else begin : g_wrap
            assign raddr = {bank[BANK_USED-1:0], mem_addr[WIN_LOG2-1:0]};
        end
    endgenerate
endmodule

// File: rtl/rbw_seq.sv
module rbw_seq
    import rbw_pkg::*;
#(
    parameter int ROM_LOG2 = 19,
    parameter int DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mem_rd,
    input  logic                claim_in,
    input  logic                wide_in,
    input  logic [ROM_LOG2-1:0] raddr_in,
    input  logic [DATA_W-1:0]   rom_rdata,
    output logic                rom_req,
    output logic [ROM_LOG2-1:0] rom_addr,
    output logic                rsp_valid,
    output logic                hit,
    output logic [DATA_W-1:0]   rsp_data
);
    localparam int LANE_W = DATA_W / 2;

    rbw_state_e state_q, state_d;
    logic        claim_q, wide_q;
    logic [ROM_LOG2-1:0] raddr_q;
    logic [DATA_W-1:0]   data_q;
    logic [DATA_W-1:0]   shaped;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (mem_rd) state_d = S_ISSUE;
            S_ISSUE: state_d = S_WAIT;
            S_WAIT:  state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Request capture and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_q <= 1'b0;
            wide_q  <= 1'b0;
            raddr_q <= '0;
            data_q  <= '1;
        end else begin
            if (state_q == S_IDLE && mem_rd) begin
                claim_q <= claim_in;
                wide_q  <= wide_in;
                raddr_q <= raddr_in;
            end
            if (state_q == S_WAIT) begin
                data_q <= shaped;
            end
        end
    end

    // Byte reads fill the upper lane with ones; misses return all ones
    generate
        if (DATA_W >= 2) begin : g_lanes
            always_comb begin
                if (!claim_q) begin
                    shaped = '1;
                end else if (wide_q) begin
                    shaped = rom_rdata;
                end else begin
                    shaped = {{(DATA_W-LANE_W){1'b1}}, rom_rdata[LANE_W-1:0]};
                end
            end
        end else begin : g_narrow
            assign shaped = claim_q ? rom_rdata : '1;
        end
    endgenerate

    // Output process
    always_comb begin
        rom_req   = 1'b0;
        rsp_valid = 1'b0;
        hit       = 1'b0;
        rsp_data  = '1;
        rom_addr  = raddr_q;
        unique case (state_q)
            S_IDLE:  ;
            S_ISSUE: rom_req = claim_q;
            S_WAIT:  ;
            S_RESP: begin
                rsp_valid = 1'b1;
                hit       = claim_q;
                rsp_data  = data_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rom_bank_window.sv
module rom_bank_window #(
    parameter int ADDR_W   = 20,
    parameter int WIN_LOG2 = 16,
    parameter int ROM_LOG2 = 19,
    parameter int CTRL_W   = 8,
    parameter int DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_we,
    input  logic [CTRL_W-1:0]   io_wdata,
    output logic [CTRL_W-1:0]   ctrl_rdata,
    input  logic                rom_present,
    input  logic                mem_rd,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_wide,
    output logic                rom_req,
    output logic [ROM_LOG2-1:0] rom_addr,
    input  logic [DATA_W-1:0]   rom_rdata,
    output logic                rsp_valid,
    output logic                hit,
    output logic [DATA_W-1:0]   rsp_data
);
    localparam int BANK_W = CTRL_W - 1;

    logic              win_en;
    logic [BANK_W-1:0] bank;
    logic              claim;
    logic [ROM_LOG2-1:0] raddr;

    rbw_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_we    (io_we),
        .io_wdata (io_wdata),
        .ctrl_q   (ctrl_rdata),
        .win_en   (win_en),
        .bank     (bank)
    );

    rbw_xlat #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2),
        .ROM_LOG2 (ROM_LOG2),
        .BANK_W   (BANK_W)
    ) u_xlat (
        .mem_addr    (mem_addr),
        .win_en      (win_en),
        .bank        (bank),
        .rom_present (rom_present),
        .claim       (claim),
        .raddr       (raddr)
    );

    rbw_seq #(.ROM_LOG2(ROM_LOG2), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .claim_in  (claim),
        .wide_in   (mem_wide),
        .raddr_in  (raddr),
        .rom_rdata (rom_rdata),
        .rom_req   (rom_req),
        .rom_addr  (rom_addr),
        .rsp_valid (rsp_valid),
        .hit       (hit),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/rbw_checker.sv
module rbw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        io_we,
    input logic [7:0]  io_wdata,
    input logic [7:0]  ctrl_rdata,
    input logic        rom_present,
    input logic [19:0] mem_addr,
    input logic        rom_req,
    input logic [18:0] rom_addr,
    input logic        rsp_valid,
    input logic        hit
);
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(io_we) && $past(rst_n) |-> ctrl_rdata == $past(io_wdata));

    p_req_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> $past(ctrl_rdata[7]));

    p_req_low_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> rom_addr[15:0] == $past(mem_addr[15:0]));

    p_req_needs_rom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> $past(rom_present));

    p_req_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> $past(mem_addr[19:16]) == 4'hA);

    p_hit_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> rsp_valid);

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_req_to_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> ##2 (rsp_valid && hit));
endmodule

bind rom_bank_window rbw_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_we       (io_we),
    .io_wdata    (io_wdata),
    .ctrl_rdata  (ctrl_rdata),
    .rom_present (rom_present),
    .mem_addr    (mem_addr),
    .rom_req     (rom_req),
    .rom_addr    (rom_addr),
    .rsp_valid   (rsp_valid),
    .hit         (hit)
);

// File: tb/rom_bank_window_tb_top.sv
module rom_bank_window_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        hit;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_we = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic        rom_present = 1'b1;
    logic        mem_rd = 1'b0;
    logic [19:0] mem_addr = '0;
    logic        mem_wide = 1'b0;
    logic        rom_req;
    logic [18:0] rom_addr;
    logic [15:0] rom_rdata = '0;
    logic        rsp_valid;
    logic        hit;
    logic [15:0] rsp_data;

    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    logic [7:0] ctrl_model = 8'h00;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_bank_window dut_i (
        .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_wdata(io_wdata),
        .ctrl_rdata(ctrl_rdata), .rom_present(rom_present), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wide(mem_wide), .rom_req(rom_req),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata), .rsp_valid(rsp_valid),
        .hit(hit), .rsp_data(rsp_data)
    );

    // ROM image content, computed from the byte address
    function automatic logic [7:0] rom_byte(input logic [18:0] a);
        return a[7:0] ^ {a[15:12], a[11:8]} ^ {a[18:16], 5'h13};
    endfunction

    always_ff @(posedge clk) begin
        if (rom_req) rom_rdata <= {rom_byte(rom_addr + 19'd1), rom_byte(rom_addr)};
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v, input string tag);
        @(negedge clk);
        io_we = 1'b1; io_wdata = v;
        @(negedge clk);
        io_we = 1'b0;
        ctrl_model = v;
        check(ctrl_rdata == v, tag, ctrl_rdata, v);
    endtask

    // Driver: compute expectation, push, pulse strobe
    task automatic do_read(input logic [19:0] a, input bit wide, input string tag, input int gap);
        exp_t e;
        logic [18:0] ra;
        logic claim;
        claim = ctrl_model[7] && rom_present && (a[19:16] == 4'hA);
        ra = {ctrl_model[2:0], a[15:0]};
        e.hit = claim;
        e.tag = tag;
        if (!claim) e.data = 16'hFFFF;
        else if (wide) e.data = {rom_byte(ra + 19'd1), rom_byte(ra)};
        else e.data = {8'hFF, rom_byte(ra)};
        sb.push_back(e);
        @(negedge clk);
        mem_rd = 1'b1; mem_addr = a; mem_wide = wide;
        @(negedge clk);
        mem_rd = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Monitor: pop on each response; the cycle count checks R9 timing
    int rd_edge = 0;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9/R10 unexpected response", 32'(rsp_data), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(hit == e.hit, {e.tag, " hit"}, 32'(hit), 32'(e.hit));
                check(rsp_data == e.data, {e.tag, " data"}, 32'(rsp_data), 32'(e.data));
            end
        end
        if (rst_n && hit && !rsp_valid)
            check(1'b0, "R9 hit without valid", 32'(hit), 32'h0);
    end

    // Timing probe for R9: the pulse comes in the cycle after the third edge
    task automatic timing_probe;
        int seen_at;
        sb.push_back('{hit: 1'b1, data: {8'hFF, rom_byte({ctrl_model[2:0], 16'h0042})}, tag: "R9 timing"});
        @(negedge clk);
        mem_rd = 1'b1; mem_addr = 20'hA0042; mem_wide = 1'b0;
        seen_at = -1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            mem_rd = 1'b0;
            if (rsp_valid && seen_at < 0) seen_at = i;
        end
        check(seen_at == 3, "R9 response cycle", seen_at, 3);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int req_cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ctrl_rdata == 8'h00, "R1 reset ctrl", ctrl_rdata, 0);
        check(rsp_valid == 1'b0, "R1 reset valid", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(20'hA1234, 1'b0, "R1 read after reset", 5);

        // R2: readback
        write_ctrl(8'h5A, "R2 readback 5A");
        write_ctrl(8'h00, "R2 readback 00");

        // R3: disabled with bank bits set
        write_ctrl(8'h03, "R2 readback 03");
        do_read(20'hA0010, 1'b0, "R3 disabled", 5);

        // R4: enabled byte reads, several banks
        write_ctrl(8'h80, "R2 readback 80");
        do_read(20'hA0000, 1'b0, "R4 bank0 low", 5);
        do_read(20'hAFFFF, 1'b0, "R4 bank0 top", 5);
        write_ctrl(8'h85, "R2 readback 85");
        do_read(20'hA7ABC, 1'b0, "R4 bank5", 5);

        // R5: bank wrap 9 vs 1, and 7F vs 7
        write_ctrl(8'h89, "R2 readback 89");
        do_read(20'hA0300, 1'b0, "R5 bank9 wraps to 1", 5);
        write_ctrl(8'hFF, "R2 readback FF");
        do_read(20'hA1111, 1'b0, "R5 bank7F wraps to 7", 5);

        // R8: wide reads incl. wrap at end of ROM
        do_read(20'hAFFFF, 1'b1, "R8 wide end of rom", 5);
        write_ctrl(8'h82, "R2 readback 82");
        do_read(20'hA2468, 1'b1, "R8 wide mid", 5);

        // R7: outside the window
        do_read(20'hB0000, 1'b0, "R7 above window", 5);
        do_read(20'h9FFFF, 1'b1, "R7 below window", 5);

        // R6: no ROM present, check no request issued
        rom_present = 1'b0;
        req_cnt = 0;
        fork
            begin
                repeat (8) begin
                    @(negedge clk);
                    if (rom_req) req_cnt++;
                end
            end
            do_read(20'hA0100, 1'b0, "R6 no rom", 5);
        join
        check(req_cnt == 0, "R6 rom_req count", req_cnt, 0);
        rom_present = 1'b1;

        // R9: exact cycle
        timing_probe();

        // R10: second strobe during flight ignored
        do_read(20'hA0020, 1'b0, "R10 first read", 0);
        mem_rd = 1'b1; mem_addr = 20'hA0021;
        @(negedge clk);
        mem_rd = 1'b0;
        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R10 no extra response", sb.size(), 0);

        // R11: write during flight does not alter it
        do_read(20'hA0777, 1'b0, "R11 in-flight read", 0);
        io_we = 1'b1; io_wdata = 8'h00;
        @(negedge clk);
        io_we = 1'b0;
        ctrl_model = 8'h00;
        repeat (5) @(negedge clk);
        do_read(20'hA0777, 1'b0, "R11 later read disabled", 5);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9 all responses seen", sb.size(), 0);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule